// File: doc/BRIEF.md
# Motion event detector

This block watches a stream of three-axis acceleration samples and produces three kinds of event pulse: motion (some enabled axis is large), rest (every enabled axis has been small for a programmed number of seconds), and free-fall (all three axes have been small for a programmed number of 5 ms periods). Each sample's magnitude per axis is the absolute value of its two's complement code. The 8-bit thresholds are scaled up by a fixed left shift, `THR_SHIFT` (4 by default), before they are compared with the sample magnitudes.

The two timed detectors are driven by external timebase strobes: `sec_tick` pulses once per second and `ff_tick` once per 5 ms. A linked mode makes motion and rest detection alternate: motion is ignored until rest has been seen, and each motion event restarts rest detection. With linked mode and auto-sleep both on, the block raises a sleep request from the rest event until the next motion event.

Samples arrive on a valid/ready interface. `smp_ready` is always high, so there is no back-pressure. Every cycle with `smp_valid` high delivers exactly one sample. The producer may hold `smp_valid` low for any number of cycles. The configuration inputs are expected to stay static while samples flow.

Top module: `motion_event_detector`

## Requirements
- R1: During reset and just after it, all event outputs and `sleep_req` are low. `smp_ready` is always high.
- R2: A sample accepted in cycle k causes `mot_evt` to be high for one cycle, in cycle k+1, if any axis selected in `mot_axes` has a magnitude strictly greater than `mot_thr << THR_SHIFT`. The mask bits are bit0 = x, bit1 = y and bit2 = z. Axes not selected, and magnitudes equal to the scaled threshold, do not cause the event.
- R3: Negative samples are compared by their absolute value.
- R4: An accepted sample whose selected `rest_axes` are all strictly below `rest_thr << THR_SHIFT` starts a rest episode, if no episode is already in progress. Each `sec_tick` during the episode adds one to its count. `rest_evt` pulses for one cycle, in the cycle after the count first reaches `rest_secs`. The event fires only once per episode.
- R5: An accepted sample that fails the rest condition ends the episode and clears its count; the same applies to the free-fall condition. A new episode needs a later sample that passes the condition. An axis exactly at the threshold fails the condition.
- R6: With `rest_secs` at 0, a sample that starts a rest episode in cycle k produces `rest_evt` in cycle k+2, without any tick.
- R7: Free-fall uses all three axes, whatever the masks, against `ff_thr << THR_SHIFT`. It counts `ff_tick`s up to `ff_time` and emits one `ff_evt` pulse per episode, in the cycle after the count is reached. Its episodes start and end like rest episodes.
- R8: With `link_en` low, motion and rest detection run at the same time and independently. One sample can produce `mot_evt` while a rest episode carries on.
- R9: With `link_en` high, samples cause no `mot_evt` until a rest event has occurred. Each `mot_evt` then ends the current rest episode, and rest detection starts again from the next passing sample.
- R10: `sleep_req` is high when `link_en` and `auto_sleep_en` are both high and the last event was a rest event. It rises in the same cycle as `rest_evt` and falls in the same cycle as `mot_evt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | A sample is present |
| smp_ready | output | 1 | Always high; no back-pressure |
| smp_x | input | SAMPLE_W | x sample, two's complement |
| smp_y | input | SAMPLE_W | y sample, two's complement |
| smp_z | input | SAMPLE_W | z sample, two's complement |
| mot_axes | input | 3 | Axes used by motion detection (bit0 x) |
| rest_axes | input | 3 | Axes used by rest detection (bit0 x) |
| mot_thr | input | THR_W | Motion threshold |
| rest_thr | input | THR_W | Rest threshold |
| rest_secs | input | ITIME_W | Rest time, in `sec_tick` periods |
| ff_thr | input | THR_W | Free-fall threshold |
| ff_time | input | FTIME_W | Free-fall time, in `ff_tick` periods |
| link_en | input | 1 | Linked motion/rest sequencing |
| auto_sleep_en | input | 1 | Enables the sleep request in linked mode |
| sec_tick | input | 1 | One-second strobe |
| ff_tick | input | 1 | 5 ms strobe |
| mot_evt | output | 1 | Motion event pulse |
| rest_evt | output | 1 | Rest event pulse |
| ff_evt | output | 1 | Free-fall event pulse |
| sleep_req | output | 1 | Sleep request level |

## Verification
Motion is due one cycle after the sample that causes it is accepted. Rest and free-fall are due one cycle after the edge that completes their condition: that edge is either the last counted tick or, with a zero time, the sample that starts the episode. So a condition completed by the stimulus of cycle k is seen in cycle k+2. The driver records each expected event in a scoreboard under the cycle in which it is due. Every cycle, a monitor compares the three pulse outputs on the falling clock edge against that entry, so both a late or early event and a missing or extra one are reported. The sleep request is sampled in the same cycles as the rest and motion pulses that move it.

// File: rtl/mdet_pkg.sv
package mdet_pkg;
  localparam int AXES = 3;

  typedef enum logic {
    PH_SEEK_REST   = 1'b0,
    PH_SEEK_MOTION = 1'b1
  } link_phase_e;
endpackage

// File: rtl/mdet_axis_cmp.sv
module mdet_axis_cmp
  import mdet_pkg::*;
#(
  parameter int SAMPLE_W  = 16,
  parameter int THR_W     = 8,
  parameter int THR_SHIFT = 4
) (
  input  logic [AXES*SAMPLE_W-1:0] smp_flat,
  input  logic [THR_W-1:0]         mot_thr,
  input  logic [THR_W-1:0]         rest_thr,
  input  logic [THR_W-1:0]         ff_thr,
  output logic [AXES-1:0]          above_mot,
  output logic [AXES-1:0]          below_rest,
  output logic [AXES-1:0]          below_ff
);
  localparam int SCL_W = THR_W + THR_SHIFT;
  localparam int CMP_W = (SAMPLE_W > SCL_W) ? SAMPLE_W : SCL_W;

  logic [CMP_W-1:0] mot_lim, rest_lim, ff_lim;
  assign mot_lim  = CMP_W'(mot_thr)  << THR_SHIFT;
  assign rest_lim = CMP_W'(rest_thr) << THR_SHIFT;
  assign ff_lim   = CMP_W'(ff_thr)   << THR_SHIFT;

  for (genvar a = 0; a < AXES; a++) begin : g_axis
    logic [SAMPLE_W-1:0] raw;
    logic [SAMPLE_W-1:0] mag;
    logic [CMP_W-1:0]    mag_w;
    assign raw   = smp_flat[a*SAMPLE_W +: SAMPLE_W];
    // two's complement magnitude; the most negative code maps to 2^(W-1)
    assign mag   = raw[SAMPLE_W-1] ? SAMPLE_W'(~raw + 1'b1) : raw;
    assign mag_w = CMP_W'(mag);
    assign above_mot[a]  = mag_w >  mot_lim;
    assign below_rest[a] = mag_w <  rest_lim;
    assign below_ff[a]   = mag_w <  ff_lim;
  end
endmodule

// File: rtl/mdet_hold_qual.sv
module mdet_hold_qual #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_valid,
  input  logic             smp_ok,
  input  logic             restart,
  input  logic             tick,
  input  logic [CNT_W-1:0] limit,
  input  logic             allow,
  output logic             fire_now,
  output logic             fire_o
);
  logic             quiet_q;
  logic             done_q;
  logic [CNT_W-1:0] cnt_q;

  assign fire_now = quiet_q && !done_q && (cnt_q >= limit) && allow;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      quiet_q <= 1'b0;
      done_q  <= 1'b0;
      cnt_q   <= '0;
      fire_o  <= 1'b0;
    end else begin
      fire_o <= fire_now;
      if (restart || (smp_valid && !smp_ok)) begin
        quiet_q <= 1'b0;
        done_q  <= 1'b0;
        cnt_q   <= '0;
      end else if (smp_valid && !quiet_q) begin
        quiet_q <= 1'b1;
        done_q  <= 1'b0;
        cnt_q   <= '0;
      end else begin
        if (quiet_q && tick && (cnt_q != '1)) cnt_q <= cnt_q + 1'b1;
        if (fire_now) done_q <= 1'b1;
      end
    end
  end

  assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |=> !fire_o);

  assert_fire_in_episode_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |-> $past(quiet_q));

  assert_break_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !smp_ok) |=> (!quiet_q && cnt_q == '0));
endmodule

// File: rtl/motion_event_detector.sv
module motion_event_detector
  import mdet_pkg::*;
#(
  parameter int SAMPLE_W  = 16,
  parameter int THR_W     = 8,
  parameter int THR_SHIFT = 4,
  parameter int ITIME_W   = 8,
  parameter int FTIME_W   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_valid,
  output logic                smp_ready,
  input  logic [SAMPLE_W-1:0] smp_x,
  input  logic [SAMPLE_W-1:0] smp_y,
  input  logic [SAMPLE_W-1:0] smp_z,
  input  logic [2:0]          mot_axes,
  input  logic [2:0]          rest_axes,
  input  logic [THR_W-1:0]    mot_thr,
  input  logic [THR_W-1:0]    rest_thr,
  input  logic [ITIME_W-1:0]  rest_secs,
  input  logic [THR_W-1:0]    ff_thr,
  input  logic [FTIME_W-1:0]  ff_time,
  input  logic                link_en,
  input  logic                auto_sleep_en,
  input  logic                sec_tick,
  input  logic                ff_tick,
  output logic                mot_evt,
  output logic                rest_evt,
  output logic                ff_evt,
  output logic                sleep_req
);
  logic [AXES*SAMPLE_W-1:0] smp_flat;
  logic [AXES-1:0]          above_mot, below_rest, below_ff;
  logic                     mot_hit, rest_ok, ff_ok;
  logic                     mot_allow, rest_allow, mot_now, rest_now;
  logic                     ff_now_unused;
  link_phase_e              phase_q;

  assign smp_ready = 1'b1;
  assign smp_flat  = {smp_z, smp_y, smp_x};

  mdet_axis_cmp #(
    .SAMPLE_W (SAMPLE_W),
    .THR_W    (THR_W),
    .THR_SHIFT(THR_SHIFT)
  ) cmp_i (
    .smp_flat  (smp_flat),
    .mot_thr   (mot_thr),
    .rest_thr  (rest_thr),
    .ff_thr    (ff_thr),
    .above_mot (above_mot),
    .below_rest(below_rest),
    .below_ff  (below_ff)
  );

  // motion: OR over selected axes; rest: AND over selected axes; free-fall: all axes
  assign mot_hit = |(above_mot & mot_axes);
  assign rest_ok = &(below_rest | ~rest_axes);
  assign ff_ok   = &below_ff;

  assign mot_allow  = !link_en || (phase_q == PH_SEEK_MOTION);
  assign rest_allow = !link_en || (phase_q == PH_SEEK_REST);
  assign mot_now    = smp_valid && mot_hit && mot_allow;

  mdet_hold_qual #(.CNT_W(ITIME_W)) rest_q_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .smp_valid(smp_valid),
    .smp_ok   (rest_ok),
    .restart  (link_en && mot_now),
    .tick     (sec_tick),
    .limit    (rest_secs),
    .allow    (rest_allow),
    .fire_now (rest_now),
    .fire_o   (rest_evt)
  );

  mdet_hold_qual #(.CNT_W(FTIME_W)) ff_q_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .smp_valid(smp_valid),
    .smp_ok   (ff_ok),
    .restart  (1'b0),
    .tick     (ff_tick),
    .limit    (ff_time),
    .allow    (1'b1),
    .fire_now (ff_now_unused),
    .fire_o   (ff_evt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mot_evt <= 1'b0;
      phase_q <= PH_SEEK_REST;
    end else begin
      mot_evt <= mot_now;
      if (!link_en)      phase_q <= PH_SEEK_REST;
      else if (rest_now) phase_q <= PH_SEEK_MOTION;
      else if (mot_now)  phase_q <= PH_SEEK_REST;
    end
  end

  assign sleep_req = auto_sleep_en && link_en && (phase_q == PH_SEEK_MOTION);

  assert_mot_from_sample_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mot_evt |-> $past(smp_valid));

  assert_link_holds_motion_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (link_en && phase_q == PH_SEEK_REST) |=> !mot_evt);

  assert_sleep_on_rest_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rest_evt && link_en && $stable(link_en) && auto_sleep_en) |-> sleep_req);

  assert_wake_on_motion_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mot_evt && $stable(link_en)) |-> !sleep_req);
endmodule

// File: tb/motion_event_detector_tb.sv
module motion_event_detector_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_valid = 1'b0;
  logic        smp_ready;
  logic [15:0] smp_x = '0, smp_y = '0, smp_z = '0;
  logic [2:0]  mot_axes = 3'b010, rest_axes = 3'b111;
  logic [7:0]  mot_thr = 8'd4, rest_thr = 8'd2, ff_thr = 8'd3;
  logic [7:0]  rest_secs = 8'd3, ff_time = 8'd2;
  logic        link_en = 1'b0, auto_sleep_en = 1'b1;
  logic        sec_tick = 1'b0, ff_tick = 1'b0;
  logic        mot_evt, rest_evt, ff_evt, sleep_req;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  bit mon_on  = 1'b0;
  logic [2:0] sb [int];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  motion_event_detector dut_i (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_x(smp_x), .smp_y(smp_y), .smp_z(smp_z),
    .mot_axes(mot_axes), .rest_axes(rest_axes),
    .mot_thr(mot_thr), .rest_thr(rest_thr), .rest_secs(rest_secs),
    .ff_thr(ff_thr), .ff_time(ff_time),
    .link_en(link_en), .auto_sleep_en(auto_sleep_en),
    .sec_tick(sec_tick), .ff_tick(ff_tick),
    .mot_evt(mot_evt), .rest_evt(rest_evt), .ff_evt(ff_evt), .sleep_req(sleep_req)
  );

  // scoreboard monitor: bit0 motion (R2), bit1 rest (R4), bit2 free-fall (R7)
  always @(negedge clk) begin
    if (mon_on) begin
      logic [2:0] obs, exp_v;
      obs   = {ff_evt, rest_evt, mot_evt};
      exp_v = sb.exists(cyc) ? sb[cyc] : 3'b000;
      for (int k = 0; k < 3; k++) begin
        if (obs[k] || exp_v[k]) begin
          n_tests++;
          if (obs[k] !== exp_v[k]) begin
            n_fail++;
            $display("FAIL %s event at cycle %0d: actual %b expected %b",
                     (k == 0) ? "R2 motion" : (k == 1) ? "R4 rest" : "R7 free-fall",
                     cyc, obs[k], exp_v[k]);
          end
        end
      end
      if (sb.exists(cyc)) sb.delete(cyc);
    end
  end

  task automatic expect_ev(input int off, input logic [2:0] ev);
    if (sb.exists(cyc + off)) sb[cyc + off] = sb[cyc + off] | ev;
    else sb[cyc + off] = ev;
  endtask

  task automatic chk(input string tag, input logic act, input logic exp_v);
    n_tests++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp_v);
    end
  endtask

  task automatic drive(input logic v, input int x, input int y, input int z,
                       input logic st, input logic ft);
    smp_valid = v;
    smp_x = 16'(x); smp_y = 16'(y); smp_z = 16'(z);
    sec_tick = st; ff_tick = ft;
    @(posedge clk);
    @(negedge clk);
    smp_valid = 1'b0; sec_tick = 1'b0; ff_tick = 1'b0;
  endtask

  task automatic sample(input int x, input int y, input int z);
    drive(1'b1, x, y, z, 1'b0, 1'b0);
  endtask
  task automatic stick();
    drive(1'b0, 0, 0, 0, 1'b1, 1'b0);
  endtask
  task automatic ftick();
    drive(1'b0, 0, 0, 0, 1'b0, 1'b1);
  endtask
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, 0, 0, 0, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired at cycle %0d: actual running expected done", cyc);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1 mot_evt in reset", mot_evt, 1'b0);
    chk("R1 rest_evt in reset", rest_evt, 1'b0);
    chk("R1 ff_evt in reset", ff_evt, 1'b0);
    chk("R1 sleep_req in reset", sleep_req, 1'b0);
    chk("R1 smp_ready high", smp_ready, 1'b1);
    rst_n = 1'b1;
    mon_on = 1'b1;
    idle(1);
    chk("R1 sleep_req after reset", sleep_req, 1'b0);

    // R2 / R3: only y selected, threshold 4<<4 = 64
    sample(100, 0, 0);              // x not selected: no event
    expect_ev(1, 3'b001);
    sample(0, -100, 0);             // R3 magnitude of negative sample
    sample(0, 64, 0);               // equal, not above
    expect_ev(1, 3'b001);
    sample(0, 65, 0);
    sample(0, -64, 0);              // R3 equal magnitude, no event
    idle(2);

    // R4: rest threshold 2<<4 = 32, time 3 seconds
    sample(10, -10, 31);
    stick();
    stick();
    sample(5, 5, 5);                // episode continues
    expect_ev(2, 3'b010);
    stick();
    idle(2);
    stick();                        // already fired in this episode
    stick();
    idle(1);

    // R5: breaking samples reset the count
    sample(0, 0, 40);
    stick(); stick(); stick();      // no episode, no event
    sample(0, 0, 0);
    stick(); stick();
    sample(-32, 0, 0);              // exactly at threshold breaks
    sample(0, 0, 0);
    stick(); stick();
    expect_ev(2, 3'b010);
    stick();
    idle(2);

    // R8: rest on x only while motion fires on y in the same sample
    rest_axes = 3'b001;
    sample(40, 0, 0);
    expect_ev(1, 3'b001);
    sample(0, 500, 0);
    stick(); stick();
    expect_ev(2, 3'b010);
    stick();
    idle(2);
    rest_axes = 3'b111;

    // R6: zero rest time
    sample(0, 40, 0);
    rest_secs = 8'd0;
    expect_ev(2, 3'b010);
    sample(0, 0, 0);
    idle(2);
    sample(1, 1, 1);                // same episode: no second event
    idle(2);

    // R7: free-fall threshold 3<<4 = 48, time 2 ticks, all axes
    rest_secs = 8'd200;
    sample(0, 0, 48);               // at threshold: not free-fall
    sample(47, -47, 0);
    ftick();
    expect_ev(2, 3'b100);
    ftick();
    idle(2);
    ftick();                        // once per episode
    sample(0, 0, -60);
    sample(0, 0, 0);
    ftick();
    sample(0, 0, 0);
    expect_ev(2, 3'b100);
    ftick();
    idle(2);

    // R9 / R10: linked mode with auto-sleep
    sample(0, 40, 0);
    rest_secs = 8'd0;
    link_en = 1'b1;
    idle(1);
    chk("R10 sleep_req low before rest", sleep_req, 1'b0);
    sample(0, 100, 0);              // R9 motion held off
    idle(1);
    expect_ev(2, 3'b010);
    sample(0, 0, 0);
    idle(1);
    chk("R10 sleep_req rises with rest", sleep_req, 1'b1);
    sample(2, 2, 2);                // no second rest event
    idle(1);
    chk("R10 sleep_req held", sleep_req, 1'b1);
    expect_ev(1, 3'b001);
    sample(0, -90, 0);
    chk("R10 sleep_req falls with motion", sleep_req, 1'b0);
    expect_ev(2, 3'b010);
    sample(0, 0, 0);                // R9 rest detection restarted
    idle(1);
    chk("R10 sleep_req after restarted rest", sleep_req, 1'b1);
    auto_sleep_en = 1'b0;
    idle(1);
    chk("R10 sleep_req needs auto-sleep", sleep_req, 1'b0);
    expect_ev(1, 3'b001);
    sample(0, 90, 0);
    idle(1);

    // R8: link off again, motion not held off
    link_en = 1'b0;
    idle(1);
    expect_ev(1, 3'b001);
    sample(0, 90, 0);
    chk("R10 sleep_req with link off", sleep_req, 1'b0);
    idle(3);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule